// File: doc/BRIEF.md
# Store Write Buffer

This block posts processor stores into a small queue so that the processor can keep executing while a slow memory or register bus absorbs them. Each store carries an address, a data word and a byte enable. The processor may push one store per clock. It is held back only when every slot is taken and no slot frees in that same cycle.

The drain side presents the oldest entry on a valid/ready memory port. It keeps that entry on the port for at least a modelled write cost, which depends on the memory page of the address. A write that starts on an idle port pays the first-access cost. A write that follows the previous one with no gap pays the sequential cost if it stays in the same page, and the page-change cost if it moves to another page. Because of this, how fast the queue empties depends on the address pattern.

An empty flag lets uncached reads or synchronising instructions wait until every posted store has reached memory. The buffer changes only the timing of stores. It never changes their content or their order.

Top module: `store_wbuf`

## Requirements
- R1: Stores leave on the memory port in exactly the order in which they were accepted.
- R2: While fewer than DEPTH (default 4) entries are held, `st_stall` is low and a store presented with `st_valid` is accepted on that clock edge, so one store per cycle can be pushed.
- R3: When DEPTH entries are held and the head write does not complete in the current cycle, `st_stall` is high and the store is not taken. If the head write completes in that cycle, `st_stall` is low and the store is accepted.
- R4: A write that starts when the memory port was idle in the previous cycle keeps `mem_valid` high for 3 cycles when `mem_ready` is high.
- R5: A write that starts in the cycle right after another write completed, in the same page (page = address bits 31 down to PAGE_BITS, default 10), keeps `mem_valid` high for 2 cycles when `mem_ready` is high.
- R6: A write that starts right after another write completed, in a different page, keeps `mem_valid` high for 7 cycles when `mem_ready` is high.
- R7: A write completes only in a cycle where `mem_ready` is high and its cost has elapsed. Until then, `mem_addr`, `mem_data` and `mem_be` stay unchanged and `mem_valid` stays high.
- R8: `wb_empty` is high exactly when no store is queued or being written. After reset, `wb_empty` is 1, `mem_valid` is 0 and `st_stall` is 0.
- R9: Address, data and byte enable appear on the memory port unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor presents a store |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enable |
| st_stall | output | 1 | Store cannot be taken this cycle |
| mem_valid | output | 1 | Memory write request valid |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enable |
| mem_ready | input | 1 | Memory can finish the presented write |
| wb_empty | output | 1 | No store queued or in flight |

## Verification
The assertions assume that the processor leaves a store unaccepted while `st_stall` is high and does not count on it being taken. They also assume that `mem_ready` may fall at any time without causing the presented write to be lost. The bench drives stores only from a task that holds `st_valid` until it sees `st_stall` low at the sampling point. It also gives every store a unique data word, so each write's duration on the port can be measured without ambiguity. `mem_ready` is lowered only in the back-pressure scenario, and only while a single write is outstanding.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wr_entry_t;

    typedef enum logic [1:0] {
        ACC_FIRST,
        ACC_SEQ,
        ACC_JUMP
    } acc_kind_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  wr_entry_t               push_entry_i,
    input  logic                    pop_i,
    output wr_entry_t               head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                    full_o,
    output logic                    empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        wr_entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[st_q.wr] = push_entry_i;
            st_d.wr            = adv(st_q.wr);
        end
        if (pop_i) begin
            st_d.rd = adv(st_q.rd);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.slot[st_q.rd];
    assign count_o = st_q.cnt;
    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);

    // R3: a push into a full queue only happens alongside a completion
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.cnt < CW'(DEPTH)) || pop_i);

    // R1: the drain never pops a slot that holds nothing
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));
endmodule

// File: rtl/wbuf_cost.sv
module wbuf_cost
    import wbuf_pkg::*;
#(
    parameter int PAGE_BITS  = 10,
    parameter int COST_FIRST = 3,
    parameter int COST_SEQ   = 2,
    parameter int COST_JUMP  = 7,
    parameter int CNT_W      = 3
) (
    input  logic                          chain_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [ADDR_W-PAGE_BITS-1:0]   last_page_i,
    output logic [ADDR_W-PAGE_BITS-1:0]   page_o,
    output logic [CNT_W-1:0]              cycles_o
);
    acc_kind_e kind;

    always_comb begin
        page_o = addr_i[ADDR_W-1:PAGE_BITS];
        if (!chain_i) begin
            kind = ACC_FIRST;
        end else if (page_o == last_page_i) begin
            kind = ACC_SEQ;
        end else begin
            kind = ACC_JUMP;
        end
        case (kind)
            ACC_FIRST: cycles_o = CNT_W'(COST_FIRST);
            ACC_SEQ:   cycles_o = CNT_W'(COST_SEQ);
            default:   cycles_o = CNT_W'(COST_JUMP);
        endcase
    end
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
#(
    parameter int PAGE_BITS  = 10,
    parameter int COST_FIRST = 3,
    parameter int COST_SEQ   = 2,
    parameter int COST_JUMP  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid_i,
    input  wr_entry_t         head_i,
    input  logic              mem_ready_i,
    output logic              mem_valid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic [BE_W-1:0]   mem_be_o,
    output logic              pop_o
);
    localparam int MAX_A = (COST_FIRST > COST_SEQ) ? COST_FIRST : COST_SEQ;
    localparam int MAXC  = (MAX_A > COST_JUMP) ? MAX_A : COST_JUMP;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int CW1   = CNT_W + 1;
    localparam int PG_W  = ADDR_W - PAGE_BITS;

    typedef struct packed {
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] cost;
        logic             chain;
        logic [PG_W-1:0]  last_page;
    } drain_st_t;

    drain_st_t st_d, st_q;

    logic [PG_W-1:0]  head_page;
    logic [CNT_W-1:0] start_cost;
    logic [CNT_W-1:0] cost_now;
    logic             start;
    logic             cost_met;

    wbuf_cost #(
        .PAGE_BITS (PAGE_BITS),
        .COST_FIRST(COST_FIRST),
        .COST_SEQ  (COST_SEQ),
        .COST_JUMP (COST_JUMP),
        .CNT_W     (CNT_W)
    ) i_cost (
        .chain_i    (st_q.chain),
        .addr_i     (head_i.addr),
        .last_page_i(st_q.last_page),
        .page_o     (head_page),
        .cycles_o   (start_cost)
    );

    always_comb begin
        st_d     = st_q;
        pop_o    = 1'b0;
        start    = (st_q.elapsed == '0);
        cost_now = start ? start_cost : st_q.cost;
        cost_met = (CW1'(st_q.elapsed) + CW1'(1)) >= CW1'(cost_now);
        if (head_valid_i) begin
            st_d.cost = cost_now;
            if (mem_ready_i && cost_met) begin
                pop_o          = 1'b1;
                st_d.elapsed   = '0;
                st_d.chain     = 1'b1;
                st_d.last_page = head_page;
            end else begin
                st_d.chain = 1'b0;
                if (st_q.elapsed != '1) begin
                    st_d.elapsed = st_q.elapsed + CNT_W'(1);
                end
            end
        end else begin
            st_d.chain   = 1'b0;
            st_d.elapsed = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid_o = head_valid_i;
    assign mem_addr_o  = head_i.addr;
    assign mem_data_o  = head_i.data;
    assign mem_be_o    = head_i.be;

    // R7: a write held back by the memory keeps its request unchanged
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
            (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o) && $stable(mem_be_o)));

    // R4: a write starting on an idle port is never a single-cycle write
    p_first_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid_o) |=> mem_valid_o);
endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
    import wbuf_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int PAGE_BITS  = 10,
    parameter int COST_FIRST = 3,
    parameter int COST_SEQ   = 2,
    parameter int COST_JUMP  = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        st_valid,
    input  logic [31:0] st_addr,
    input  logic [31:0] st_data,
    input  logic [3:0]  st_be,
    output logic        st_stall,
    output logic        mem_valid,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    output logic [3:0]  mem_be,
    input  logic        mem_ready,
    output logic        wb_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    wr_entry_t      push_entry;
    wr_entry_t      head;
    logic           push;
    logic           pop;
    logic           full;
    logic           empty;
    logic [CW-1:0]  count;

    assign push_entry = '{addr: st_addr, data: st_data, be: st_be};
    assign st_stall   = full && !pop;
    assign push       = st_valid && !st_stall;
    assign wb_empty   = empty;

    wbuf_fifo #(
        .DEPTH(DEPTH)
    ) i_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_entry_i(push_entry),
        .pop_i       (pop),
        .head_o      (head),
        .count_o     (count),
        .full_o      (full),
        .empty_o     (empty)
    );

    wbuf_drain #(
        .PAGE_BITS (PAGE_BITS),
        .COST_FIRST(COST_FIRST),
        .COST_SEQ  (COST_SEQ),
        .COST_JUMP (COST_JUMP)
    ) i_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_valid_i(!empty),
        .head_i      (head),
        .mem_ready_i (mem_ready),
        .mem_valid_o (mem_valid),
        .mem_addr_o  (mem_addr),
        .mem_data_o  (mem_data),
        .mem_be_o    (mem_be),
        .pop_o       (pop)
    );

    // R8: an empty buffer presents no memory request
    p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_empty |-> !mem_valid);

    // R2: stall is raised only with every slot occupied
    p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (count == CW'(DEPTH)));

    // R3: an accepted store is counted in the next cycle unless one drained
    p_push_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + CW'(1)));
endmodule

// File: tb/test_store_wbuf.sv
module test_store_wbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_stall;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b1;
    logic        wb_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    store_wbuf i_store_wbuf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .mem_ready(mem_ready), .wb_empty(wb_empty)
    );

    // observed writes on the memory port
    logic [31:0] lg_a [32];
    logic [31:0] lg_d [32];
    logic [3:0]  lg_b [32];
    int          lg_len [32];
    int          n_log = 0;
    bit          open_w = 1'b0;
    logic [31:0] cur_a, cur_d;
    logic [3:0]  cur_b;
    int          cur_len = 0;

    // expected writes
    logic [31:0] ex_a [32];
    logic [31:0] ex_d [32];
    logic [3:0]  ex_b [32];
    int          ex_len [32];
    string       ex_tag [32];
    int          n_ex = 0;

    task automatic close_w();
        if (n_log < 32) begin
            lg_a[n_log] = cur_a; lg_d[n_log] = cur_d;
            lg_b[n_log] = cur_b; lg_len[n_log] = cur_len;
        end
        n_log++;
    endtask

    always @(negedge clk) begin
        if (mem_valid) begin
            if (open_w && mem_addr == cur_a && mem_data == cur_d && mem_be == cur_b) begin
                cur_len++;
            end else begin
                if (open_w) close_w();
                open_w = 1'b1;
                cur_a = mem_addr; cur_d = mem_data; cur_b = mem_be; cur_len = 1;
            end
        end else if (open_w) begin
            close_w();
            open_w = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_log = 0;
        n_ex  = 0;
    endtask

    task automatic do_push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b,
                           input int cost, input string tag, output int stalls);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = b;
        stalls = 0;
        while (st_stall) begin
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        #1 st_valid = 1'b0;
        ex_a[n_ex] = a; ex_d[n_ex] = d; ex_b[n_ex] = b;
        ex_len[n_ex] = cost; ex_tag[n_ex] = tag;
        n_ex++;
    endtask

    task automatic wait_drain();
        @(negedge clk);
        while (!wb_empty) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_log();
        chk(n_log == n_ex, "R1 write count", n_log, n_ex);
        for (int i = 0; i < n_ex && i < n_log; i++) begin
            chk(lg_a[i] == ex_a[i], "R1 order/addr", lg_a[i], ex_a[i]);
            chk(lg_d[i] == ex_d[i], "R9 data", lg_d[i], ex_d[i]);
            chk(lg_b[i] == ex_b[i], "R9 byte enable", lg_b[i], ex_b[i]);
            chk(lg_len[i] == ex_len[i], ex_tag[i], lg_len[i], ex_len[i]);
        end
    endtask

    task automatic t_reset();
        chk(wb_empty == 1'b1, "R8 reset empty", wb_empty, 1);
        chk(mem_valid == 1'b0, "R8 reset mem_valid", mem_valid, 0);
        chk(st_stall == 1'b0, "R8 reset stall", st_stall, 0);
    endtask

    task automatic t_single();
        int s;
        clear_logs();
        do_push(32'h0000_1000, 32'hA000_0001, 4'hF, 3, "R4 first cost", s);
        @(negedge clk);
        chk(wb_empty == 1'b0, "R8 busy not empty", wb_empty, 0);
        wait_drain();
        chk(wb_empty == 1'b1, "R8 empty after drain", wb_empty, 1);
        check_log();
    endtask

    task automatic t_same_page();
        int s;
        clear_logs();
        do_push(32'h0000_1004, 32'hB000_0001, 4'h1, 3, "R4 first cost", s);
        do_push(32'h0000_1008, 32'hB000_0002, 4'h3, 2, "R5 seq cost", s);
        chk(s == 0, "R2 no stall", s, 0);
        do_push(32'h0000_13FC, 32'hB000_0003, 4'hC, 2, "R5 seq cost", s);
        wait_drain();
        check_log();
    endtask

    task automatic t_page_jump();
        int s;
        clear_logs();
        do_push(32'h0000_1000, 32'hC000_0001, 4'hF, 3, "R4 first cost", s);
        do_push(32'h0000_1400, 32'hC000_0002, 4'h2, 7, "R6 jump cost", s);
        do_push(32'h0000_1404, 32'hC000_0003, 4'h4, 2, "R5 seq cost", s);
        do_push(32'h0000_1010, 32'hC000_0004, 4'h8, 7, "R6 jump cost", s);
        wait_drain();
        check_log();
    endtask

    task automatic t_full();
        int s;
        clear_logs();
        for (int i = 0; i < 5; i++) begin
            do_push(32'h0000_1000 + (i[0] ? 32'h400 : 32'h0) + 32'(i * 4),
                    32'hD000_0000 + 32'(i), 4'hF, (i == 0) ? 3 : 7,
                    (i == 0) ? "R4 first cost" : "R6 jump cost", s);
            chk(s == 0, "R2 accept while free", s, 0);
        end
        do_push(32'h0000_1414, 32'hD000_0005, 4'h5, 7, "R6 jump cost", s);
        chk(s == 5, "R3 stall until completion", s, 5);
        wait_drain();
        check_log();
    endtask

    task automatic t_backpressure();
        int s;
        clear_logs();
        mem_ready = 1'b0;
        do_push(32'h0000_2000, 32'hE000_0001, 4'h6, 5, "R7 ready stretch", s);
        repeat (5) @(negedge clk);
        mem_ready = 1'b1;
        wait_drain();
        check_log();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_same_page();
        t_page_jump();
        t_full();
        t_backpressure();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule